// File: doc/BRIEF.md
# Instruction Pair Hazard Classifier

This block compares two instructions in program order, an older one and a younger one, and reports every register data hazard between them. Each instruction is presented as a valid bit, a destination index with a write enable, and two source indices with read enables. Three registered flags come out: a true dependence (read-after-write) and the two name dependences (write-after-read and write-after-write).

When the rename control is high, the two name-dependence flags are held low, since giving each write a fresh physical name removes those conflicts. The true dependence is still reported. Register index zero is a constant register and never takes part in a hazard. The flags are registered, so each input pair is reflected one clock later.

Top module: `hazard_pair_classifier`

## Requirements
- R1: The read-after-write flag is 1 when the younger instruction has an enabled source equal to the older instruction's enabled destination.
- R2: The write-after-read flag is 1 when the younger instruction's enabled destination equals an enabled source of the older instruction and rename is 0.
- R3: The write-after-write flag is 1 when both enabled destinations are equal and rename is 0.
- R4: When rename is 1, the write-after-read and write-after-write flags are 0, and read-after-write is unaffected.
- R5: A source or destination whose enable is 0, or either instruction having valid 0, causes no flag.
- R6: Register index 0 never causes any flag.
- R7: All flags are registered: the flags after a rising edge reflect the inputs sampled at that edge.
- R8: A synchronous reset clears all three flags at the next edge.
- R9: Several flags may be 1 together when several conditions hold for the same pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rename_on | input | 1 | Name-hazard suppression |
| old_vld | input | 1 | Older instruction valid |
| old_dst | input | REG_W | Older destination index |
| old_dst_en | input | 1 | Older writes a register |
| old_s0 | input | REG_W | Older first source |
| old_s0_en | input | 1 | Older reads first source |
| old_s1 | input | REG_W | Older second source |
| old_s1_en | input | 1 | Older reads second source |
| yng_vld | input | 1 | Younger instruction valid |
| yng_dst | input | REG_W | Younger destination index |
| yng_dst_en | input | 1 | Younger writes a register |
| yng_s0 | input | REG_W | Younger first source |
| yng_s0_en | input | 1 | Younger reads first source |
| yng_s1 | input | REG_W | Younger second source |
| yng_s1_en | input | 1 | Younger reads second source |
| raw_o | output | 1 | Read-after-write hazard |
| war_o | output | 1 | Write-after-read hazard |
| waw_o | output | 1 | Write-after-write hazard |

## Verification
The bench builds the block with its default index width of 5, giving 32 registers, so index 0 and the top index 31 are both reachable as operand values. With this width a pair can match on every source and destination at once, which brings the combined flag cases and the zero-register exclusion within reach of short vectors.

// File: rtl/hazard_pair_classifier.sv
module hazard_pair_classifier #(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rename_on,
  input  logic             old_vld,
  input  logic [REG_W-1:0] old_dst,
  input  logic             old_dst_en,
  input  logic [REG_W-1:0] old_s0,
  input  logic             old_s0_en,
  input  logic [REG_W-1:0] old_s1,
  input  logic             old_s1_en,
  input  logic             yng_vld,
  input  logic [REG_W-1:0] yng_dst,
  input  logic             yng_dst_en,
  input  logic [REG_W-1:0] yng_s0,
  input  logic             yng_s0_en,
  input  logic [REG_W-1:0] yng_s1,
  input  logic             yng_s1_en,
  output logic             raw_o,
  output logic             war_o,
  output logic             waw_o
);
  localparam logic [REG_W-1:0] ZERO_REG = '0;

  logic both_vld;
  logic o_wr, o_r0, o_r1, y_wr, y_r0, y_r1;
  logic raw_n, war_n, waw_n;

  assign both_vld = old_vld & yng_vld;

  assign o_wr = both_vld & old_dst_en & (old_dst != ZERO_REG);
  assign o_r0 = both_vld & old_s0_en  & (old_s0  != ZERO_REG);
  assign o_r1 = both_vld & old_s1_en  & (old_s1  != ZERO_REG);
  assign y_wr = both_vld & yng_dst_en & (yng_dst != ZERO_REG);
  assign y_r0 = both_vld & yng_s0_en  & (yng_s0  != ZERO_REG);
  assign y_r1 = both_vld & yng_s1_en  & (yng_s1  != ZERO_REG);

  assign raw_n = o_wr & ((y_r0 & (yng_s0 == old_dst)) | (y_r1 & (yng_s1 == old_dst)));
  assign war_n = ~rename_on & y_wr & ((o_r0 & (old_s0 == yng_dst)) | (o_r1 & (old_s1 == yng_dst)));
  assign waw_n = ~rename_on & o_wr & y_wr & (old_dst == yng_dst);

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_o <= 1'b0;
      war_o <= 1'b0;
      waw_o <= 1'b0;
    end else begin
      raw_o <= raw_n;
      war_o <= war_n;
      waw_o <= waw_n;
    end
  end
endmodule

module hazard_pair_classifier_chk #(
  parameter int REG_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             rename_on,
  input logic             old_vld,
  input logic [REG_W-1:0] old_dst,
  input logic             old_dst_en,
  input logic             yng_vld,
  input logic [REG_W-1:0] yng_dst,
  input logic             yng_dst_en,
  input logic             raw_o,
  input logic             war_o,
  input logic             waw_o
);
  logic started;
  always_ff @(posedge clk) started <= 1'b1;

  a_r4_rename_kills_names: assert property (@(posedge clk) disable iff (rst)
    started && rename_on |=> !war_o && !waw_o);

  a_r5_invalid_quiet: assert property (@(posedge clk) disable iff (rst)
    started && !(old_vld && yng_vld) |=> !raw_o && !war_o && !waw_o);

  a_r3_waw_match: assert property (@(posedge clk) disable iff (rst)
    started && old_vld && yng_vld && old_dst_en && yng_dst_en && !rename_on
    && old_dst == yng_dst && old_dst != '0 |=> waw_o);

  a_r6_zero_dst_no_waw: assert property (@(posedge clk) disable iff (rst)
    started && (old_dst == '0 || yng_dst == '0) |=> !waw_o);

  a_r8_reset_clears: assert property (@(posedge clk)
    started && rst |=> !raw_o && !war_o && !waw_o);
endmodule

bind hazard_pair_classifier hazard_pair_classifier_chk #(.REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst), .rename_on(rename_on),
  .old_vld(old_vld), .old_dst(old_dst), .old_dst_en(old_dst_en),
  .yng_vld(yng_vld), .yng_dst(yng_dst), .yng_dst_en(yng_dst_en),
  .raw_o(raw_o), .war_o(war_o), .waw_o(waw_o)
);

// File: tb/sim_hazard_pair_classifier.sv
module sim_hazard_pair_classifier;
  logic clk = 0, rst = 1, ren = 0;
  logic ov, oden, o0en, o1en, yv, yden, y0en, y1en;
  logic [4:0] od, o0, o1, yd, y0, y1;
  logic raw, war, waw;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  hazard_pair_classifier u0 (
    .clk(clk), .rst(rst), .rename_on(ren),
    .old_vld(ov), .old_dst(od), .old_dst_en(oden),
    .old_s0(o0), .old_s0_en(o0en), .old_s1(o1), .old_s1_en(o1en),
    .yng_vld(yv), .yng_dst(yd), .yng_dst_en(yden),
    .yng_s0(y0), .yng_s0_en(y0en), .yng_s1(y1), .yng_s1_en(y1en),
    .raw_o(raw), .war_o(war), .waw_o(waw));

  // ren, ov, od, oden, o0, o0en, o1, o1en, yv, yd, yden, y0, y0en, y1, y1en, raw, war, waw
  typedef struct packed {
    logic ren, ov; logic [4:0] od; logic oden; logic [4:0] o0; logic o0en;
    logic [4:0] o1; logic o1en; logic yv; logic [4:0] yd; logic yden;
    logic [4:0] y0; logic y0en; logic [4:0] y1; logic y1en;
    logic raw, war, waw; logic [7:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VT [NV] = '{
    '{0,1,5'd1,1,5'd2,1,5'd3,1, 1,5'd4,1,5'd1,1,5'd3,1, 1,0,0, 8'd1}, // R1 s0 match
    '{0,1,5'd7,1,5'd2,1,5'd3,1, 1,5'd4,1,5'd8,1,5'd7,1, 1,0,0, 8'd1}, // R1 s1 match
    '{0,1,5'd4,1,5'd1,1,5'd3,1, 1,5'd1,1,5'd2,1,5'd3,1, 0,1,0, 8'd2}, // R2
    '{0,1,5'd1,1,5'd4,1,5'd3,1, 1,5'd1,1,5'd2,1,5'd3,1, 0,0,1, 8'd3}, // R3
    '{1,1,5'd1,1,5'd4,1,5'd3,1, 1,5'd1,1,5'd1,1,5'd4,1, 1,0,0, 8'd4}, // R4 all suppressed but RAW
    '{0,1,5'd1,1,5'd2,1,5'd3,1, 1,5'd4,1,5'd1,0,5'd3,1, 0,0,0, 8'd5}, // R5 src en off
    '{0,0,5'd1,1,5'd2,1,5'd3,1, 1,5'd1,1,5'd1,1,5'd2,1, 0,0,0, 8'd5}, // R5 old invalid
    '{0,1,5'd1,0,5'd2,1,5'd3,1, 1,5'd1,1,5'd1,1,5'd3,1, 0,0,0, 8'd5}, // R5 old dst en off
    '{0,1,5'd0,1,5'd0,1,5'd0,1, 1,5'd0,1,5'd0,1,5'd0,1, 0,0,0, 8'd6}, // R6
    '{0,1,5'd31,1,5'd31,1,5'd3,1, 1,5'd31,1,5'd31,1,5'd3,1, 1,1,1, 8'd9}, // R9 all
    '{0,1,5'd9,1,5'd9,1,5'd3,0, 1,5'd9,1,5'd2,1,5'd2,1, 0,1,1, 8'd9}, // R9 war+waw
    '{0,1,5'd5,1,5'd6,1,5'd7,1, 1,5'd8,1,5'd9,1,5'd10,1, 0,0,0, 8'd1}  // R1 no overlap
  };

  task automatic apply(input vec_t v);
    ren = v.ren; ov = v.ov; od = v.od; oden = v.oden; o0 = v.o0; o0en = v.o0en;
    o1 = v.o1; o1en = v.o1en; yv = v.yv; yd = v.yd; yden = v.yden;
    y0 = v.y0; y0en = v.y0en; y1 = v.y1; y1en = v.y1en;
  endtask

  task automatic chk(input logic er, ew, ex, input string tag);
    checks++;
    if ({raw, war, waw} !== {er, ew, ex}) begin
      fails++;
      $display("FAIL %s got raw/war/waw=%b%b%b exp=%b%b%b", tag, raw, war, waw, er, ew, ex);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    apply(VT[9]);
    @(posedge clk); @(posedge clk); #2;
    chk(0, 0, 0, "R8 reset state");
    rst = 0;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk); apply(VT[i]);
      @(posedge clk); #2;
      chk(VT[i].raw, VT[i].war, VT[i].waw, $sformatf("R%0d vec%0d", VT[i].req, i));
    end
    // R7: output holds previous pair until the edge
    @(negedge clk); apply(VT[9]);
    @(posedge clk); #2; chk(1, 1, 1, "R7 load all");
    @(negedge clk); apply(VT[11]); #1;
    chk(1, 1, 1, "R7 held before edge");
    @(posedge clk); #2; chk(0, 0, 0, "R7 updated after edge");
    // R4 toggling rename on the same pair
    @(negedge clk); apply(VT[9]); ren = 1;
    @(posedge clk); #2; chk(1, 0, 0, "R4 rename on keeps raw");
    // R5 younger invalid
    @(negedge clk); ren = 0; yv = 0;
    @(posedge clk); #2; chk(0, 0, 0, "R5 younger invalid");
    // R8 reset mid-run
    @(negedge clk); apply(VT[9]);
    @(posedge clk); #2; chk(1, 1, 1, "R9 before reset");
    @(negedge clk); rst = 1;
    @(posedge clk); #2; chk(0, 0, 0, "R8 sync reset clears");
    rst = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule